// File: doc/BRIEF.md
# Skew-Compensating Parallel Bus Receiver

This block sits at the receiving end of a wide point-to-point link between chips. Each wire of that link reaches the receiver with its own delay, measured in whole clock cycles, so the bits of one transmitted word arrive spread over several cycles. Several words can therefore be in transit on a wire at once. The receiver measures each wire's delay against a known training word. It captures every bit at the cycle where that bit's copy of a word is present, and it holds the early bits back until the latest bit of the same word has arrived. The core logic then receives one aligned word, marked by a valid strobe.

A training run happens on its own after reset. It can be repeated while the link is in service. Three sources start a new run: a service request, a pulse from a periodic timer, or a link-error indication. While a run is in progress no word is marked valid. The newly measured delays are put into use only when no framed word is in transit, so no delivered word is ever assembled from two different delay settings. If some wire never shows its training bit within the measurable range, the run is declared failed. Delivery then stays off until a later run succeeds.

The transmitter launches the frame marker `frame_in` and the training marker `train_mark` with zero skew. It drives the complement of the training word on the data wires whenever it is not sending the training word during a run.

Top module: `deskew_rx`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `data_vld`, `cal_done` and `cal_fail` are 0. After reset a training run is already armed with no trigger: a `train_mark` with no frames around it makes `cal_done` 1 as seen in the 9th cycle after the marker cycle.
- R2: The delay of wire i is the offset k, from 0 to MAXD=7, of the first cycle at or after the `train_mark` cycle in which `bus_in[i]` equals bit i of TRAIN (default 8'hA5).
- R3: A word presented with `frame_in` high shows up whole on `data_out`, with every bit taken from that same word, in the cycle in which `data_vld` is high.
- R4: The delivery latency, from the cycle in which `frame_in` is presented to the cycle in which `data_vld` and `data_out` show the word, is the largest measured wire delay plus one cycle. Each wire is padded by the largest delay minus its own delay.
- R5: When no run is in progress, a pulse on `svc_cal_req`, `timer_tick` or `link_err` starts a run. In the following cycle `cal_done` and `cal_fail` are 0.
- R6: `data_vld` is 0 in every cycle that follows a cycle with `cal_done` 0. This includes frames presented during a run.
- R7: The new delays are put into use (the cycle in which `cal_done` rises) at the first clock edge after the end of the measurement window at which `frame_in` is low and no frame was sampled in the previous MAXD edges. Frames presented right after the marker therefore delay `cal_done`.
- R8: If any wire has no matching cycle within offsets 0 to MAXD, `cal_fail` goes to 1 in the 8th cycle after the marker cycle. `cal_done` stays 0, the old delays are kept, and no frame is delivered.
- R9: A later successful run clears `cal_fail` and restores delivery with the newly measured delays.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receiver clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_in | input | WIDTH | Raw skewed data wires |
| frame_in | input | 1 | Unskewed marker: a word was launched in this cycle |
| train_mark | input | 1 | Unskewed marker: the training word was launched in this cycle |
| svc_cal_req | input | 1 | Service request to rerun training |
| timer_tick | input | 1 | Periodic timer pulse to rerun training |
| link_err | input | 1 | Detected link error, reruns training |
| data_out | output | WIDTH | Aligned word |
| data_vld | output | 1 | Strobe marking a delivered aligned word |
| cal_done | output | 1 | Delays are measured and in use |
| cal_fail | output | 1 | Last run found a wire outside the delay range |

## Verification
The two functions that can coincide are the end of a measurement run and the passage of framed words through the deskew lines. The new delays must not be committed under a word that is still in transit. The bench launches three frames immediately behind the training marker, with all wires unskewed. It then expects `cal_done` to appear three cycles later than in an undisturbed run, and it expects none of those frames to be strobed valid. The other runs are judged by the exact cycle of `cal_done`, and every delivered word is compared against the launched word and its launch cycle.

// File: rtl/deskew_pkg.sv
package deskew_pkg;

    // Calibration sequencer states
    typedef enum logic [1:0] {
        CAL_IDLE = 2'd0,
        CAL_WAIT = 2'd1,
        CAL_MEAS = 2'd2,
        CAL_PEND = 2'd3
    } cal_state_e;

    // Sources that may start a training run
    typedef struct packed {
        logic svc;
        logic tmr;
        logic err;
    } cal_trig_t;

    function automatic logic trig_any(input cal_trig_t t);
        return t.svc | t.tmr | t.err;
    endfunction

endpackage

// File: rtl/deskew_lane.sv
// One wire's adjustable delay: a shift line of MAXD stages and a tap mux.
// pad = 0 passes the input straight to the mux output.
module deskew_lane #(
    parameter int MAXD = 7,
    localparam int DW = $clog2(MAXD + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          din,
    input  logic [DW-1:0] pad,
    output logic          dout
);
    logic [MAXD-1:0] line;
    logic [DW-1:0]   tap_idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            line <= '0;
        end else begin
            line[0] <= din;
            for (int j = 1; j < MAXD; j++) begin
                line[j] <= line[j-1];
            end
        end
    end

    assign tap_idx = pad - 1'b1;

    always_comb begin
        if (pad == '0) dout = din;
        else           dout = line[tap_idx];
    end

endmodule

// File: rtl/deskew_calib.sv
// Training sequencer: measures each wire's delay after the training marker,
// flags failure, and commits the pad settings only while no frame is in flight.
module deskew_calib
    import deskew_pkg::*;
#(
    parameter int          WIDTH = 8,
    parameter int          MAXD  = 7,
    parameter logic [WIDTH-1:0] TRAIN = 8'hA5,
    localparam int DW = $clog2(MAXD + 1)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [WIDTH-1:0]          bus_in,
    input  logic                      train_mark,
    input  logic                      frame_in,
    input  cal_trig_t                 trig,
    output logic [WIDTH-1:0][DW-1:0]  pad_o,
    output logic [DW-1:0]             maxd_o,
    output logic                      calibrating,
    output logic                      cal_done,
    output logic                      cal_fail
);
    cal_state_e                st;
    logic [DW-1:0]             k;
    logic [WIDTH-1:0][DW-1:0]  meas;
    logic [WIDTH-1:0]          found;
    logic [WIDTH-1:0]          hit;
    logic [WIDTH-1:0]          found_nxt;
    logic [DW-1:0]             meas_max;
    logic [DW-1:0]             inflight;
    logic                      frame_busy;

    assign hit       = ~(bus_in ^ TRAIN);
    assign found_nxt = found | hit;

    always_comb begin
        meas_max = '0;
        for (int i = 0; i < WIDTH; i++) begin
            if (meas[i] > meas_max) meas_max = meas[i];
        end
    end

    // A sampled frame stays inside the frame line for MAXD edges.
    always_ff @(posedge clk) begin
        if (rst)                  inflight <= '0;
        else if (frame_in)        inflight <= DW'(MAXD);
        else if (inflight != '0)  inflight <= inflight - 1'b1;
    end
    assign frame_busy = frame_in | (inflight != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= CAL_WAIT;
            k        <= '0;
            meas     <= '0;
            found    <= '0;
            pad_o    <= '0;
            maxd_o   <= '0;
            cal_done <= 1'b0;
            cal_fail <= 1'b0;
        end else begin
            case (st)
                CAL_IDLE: begin
                    if (trig_any(trig)) begin
                        st       <= CAL_WAIT;
                        cal_done <= 1'b0;
                        cal_fail <= 1'b0;
                    end
                end
                CAL_WAIT: begin
                    if (train_mark) begin
                        st    <= CAL_MEAS;
                        k     <= DW'(1);
                        found <= hit;
                        meas  <= '0;
                    end
                end
                CAL_MEAS: begin
                    for (int i = 0; i < WIDTH; i++) begin
                        if (!found[i] && hit[i]) meas[i] <= k;
                    end
                    found <= found_nxt;
                    if (k == DW'(MAXD)) begin
                        if (&found_nxt) begin
                            st <= CAL_PEND;
                        end else begin
                            st       <= CAL_IDLE;
                            cal_fail <= 1'b1;
                        end
                    end else begin
                        k <= k + 1'b1;
                    end
                end
                CAL_PEND: begin
                    if (!frame_busy) begin
                        for (int i = 0; i < WIDTH; i++) begin
                            pad_o[i] <= meas_max - meas[i];
                        end
                        maxd_o   <= meas_max;
                        cal_done <= 1'b1;
                        st       <= CAL_IDLE;
                    end
                end
                default: st <= CAL_IDLE;
            endcase
        end
    end

    assign calibrating = (st != CAL_IDLE);

endmodule

// File: rtl/deskew_rx.sv
// Top: per-wire deskew lanes, a frame-marker lane padded by the largest
// delay, and the training sequencer. Outputs are registered.
module deskew_rx
    import deskew_pkg::*;
#(
    parameter int               WIDTH = 8,
    parameter int               MAXD  = 7,
    parameter logic [WIDTH-1:0] TRAIN = 8'hA5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] bus_in,
    input  logic             frame_in,
    input  logic             train_mark,
    input  logic             svc_cal_req,
    input  logic             timer_tick,
    input  logic             link_err,
    output logic [WIDTH-1:0] data_out,
    output logic             data_vld,
    output logic             cal_done,
    output logic             cal_fail
);
    localparam int DW = $clog2(MAXD + 1);

    logic [WIDTH-1:0][DW-1:0] pad;
    logic [DW-1:0]            maxd;
    logic [WIDTH-1:0]         lane_sel;
    logic                     frame_sel;
    logic                     calibrating;
    cal_trig_t                trig;

    assign trig = '{svc: svc_cal_req, tmr: timer_tick, err: link_err};

    deskew_calib #(
        .WIDTH (WIDTH),
        .MAXD  (MAXD),
        .TRAIN (TRAIN)
    ) u_calib (
        .clk         (clk),
        .rst         (rst),
        .bus_in      (bus_in),
        .train_mark  (train_mark),
        .frame_in    (frame_in),
        .trig        (trig),
        .pad_o       (pad),
        .maxd_o      (maxd),
        .calibrating (calibrating),
        .cal_done    (cal_done),
        .cal_fail    (cal_fail)
    );

    for (genvar gi = 0; gi < WIDTH; gi++) begin : g_lane
        deskew_lane #(.MAXD(MAXD)) u_lane (
            .clk  (clk),
            .rst  (rst),
            .din  (bus_in[gi]),
            .pad  (pad[gi]),
            .dout (lane_sel[gi])
        );
    end

    deskew_lane #(.MAXD(MAXD)) u_frame_lane (
        .clk  (clk),
        .rst  (rst),
        .din  (frame_in),
        .pad  (maxd),
        .dout (frame_sel)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            data_out <= '0;
            data_vld <= 1'b0;
        end else begin
            data_out <= lane_sel;
            data_vld <= frame_sel & cal_done;
        end
    end

endmodule

// File: rtl/deskew_rx_chk.sv
module deskew_rx_chk (
    input logic clk,
    input logic rst,
    input logic frame_in,
    input logic svc_cal_req,
    input logic timer_tick,
    input logic link_err,
    input logic data_vld,
    input logic cal_done,
    input logic cal_fail,
    input logic calibrating
);
    assert_reset_quiet_R1: assert property (@(posedge clk)
        $fell(rst) |-> (!data_vld && !cal_done && !cal_fail));

    assert_trigger_starts_R5: assert property (@(posedge clk) disable iff (rst)
        ((svc_cal_req || timer_tick || link_err) && !calibrating)
        |=> (calibrating && !cal_done && !cal_fail));

    assert_no_valid_uncal_R6: assert property (@(posedge clk) disable iff (rst)
        !cal_done |=> !data_vld);

    assert_running_not_done_R6: assert property (@(posedge clk) disable iff (rst)
        calibrating |-> !cal_done);

    assert_commit_gap_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(cal_done) |-> !$past(frame_in));

    assert_fail_excl_R8: assert property (@(posedge clk) disable iff (rst)
        cal_fail |-> !cal_done);
endmodule

bind deskew_rx deskew_rx_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .frame_in    (frame_in),
    .svc_cal_req (svc_cal_req),
    .timer_tick  (timer_tick),
    .link_err    (link_err),
    .data_vld    (data_vld),
    .cal_done    (cal_done),
    .cal_fail    (cal_fail),
    .calibrating (calibrating)
);

// File: tb/deskew_rx_bench.sv
`timescale 1ns/1ps
module deskew_rx_bench;
    localparam int          WIDTH = 8;
    localparam int          HDEP  = 16;
    localparam logic [7:0]  TRAIN = 8'hA5;
    localparam logic [7:0]  IDLE  = ~TRAIN;

    // {trigger[1:0], expected largest delay[3:0], per-wire skew nibbles[31:0]}
    localparam logic [37:0] VEC [5] = '{
        {2'd0, 4'd0, 32'h00000000},
        {2'd1, 4'd7, 32'h76543210},
        {2'd2, 4'd3, 32'h30210312},
        {2'd0, 4'd7, 32'h77777777},
        {2'd1, 4'd5, 32'h01234500}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [WIDTH-1:0] bus_in = '0;
    logic frame_in = 1'b0, train_mark = 1'b0;
    logic svc_cal_req = 1'b0, timer_tick = 1'b0, link_err = 1'b0;
    logic [WIDTH-1:0] data_out;
    logic data_vld, cal_done, cal_fail;

    always #2 clk = ~clk;

    deskew_rx u_deskew_rx (
        .clk(clk), .rst(rst), .bus_in(bus_in), .frame_in(frame_in),
        .train_mark(train_mark), .svc_cal_req(svc_cal_req),
        .timer_tick(timer_tick), .link_err(link_err),
        .data_out(data_out), .data_vld(data_vld),
        .cal_done(cal_done), .cal_fail(cal_fail)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_chk = 0, n_fail = 0;
    logic finished = 1'b0;
    logic [WIDTH-1:0] hist [HDEP];
    int skew [WIDTH];
    logic [WIDTH-1:0] exp_w [256];
    int exp_t [256];
    int wr = 0, rd = 0, recv = 0, exp_lat = 1;

    task automatic chk(input logic ok, input string tag, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    // Output monitor: every strobe must match the oldest launched word
    always @(negedge clk) begin
        if (!rst && data_vld) begin
            if (rd == wr) begin
                chk(1'b0, "R6 strobe with no word pending", 1, 0);
            end else begin
                chk(data_out == exp_w[rd % 256], "R2,R3 aligned word",
                    int'(data_out), int'(exp_w[rd % 256]));
                chk((cyc - exp_t[rd % 256]) == exp_lat, "R4 latency",
                    cyc - exp_t[rd % 256], exp_lat);
                rd++;
                recv++;
            end
        end
    end

    task automatic step(input logic [WIDTH-1:0] w, input logic fr,
                        input logic mk, input logic push);
        @(negedge clk);
        svc_cal_req = 1'b0; timer_tick = 1'b0; link_err = 1'b0;
        for (int j = HDEP - 1; j > 0; j--) hist[j] = hist[j-1];
        hist[0] = w;
        for (int i = 0; i < WIDTH; i++) bus_in[i] = hist[skew[i]][i];
        frame_in = fr;
        train_mark = mk;
        if (push) begin
            exp_w[wr % 256] = w;
            exp_t[wr % 256] = cyc;
            wr++;
        end
    endtask

    task automatic fire(input int which);
        step(IDLE, 1'b0, 1'b0, 1'b0);
        case (which)
            0:       svc_cal_req = 1'b1;
            1:       timer_tick  = 1'b1;
            default: link_err    = 1'b1;
        endcase
    endtask

    task automatic train();
        for (int j = 0; j < HDEP; j++) step(IDLE, 1'b0, 1'b0, 1'b0);
        step(TRAIN, 1'b0, 1'b1, 1'b0);
    endtask

    task automatic wait_done(inout int n);
        for (int j = 0; j < 40; j++) begin
            step(IDLE, 1'b0, 1'b0, 1'b0);
            n++;
            if (cal_done || cal_fail) break;
        end
    endtask

    task automatic set_skew(input logic [31:0] cfg);
        for (int i = 0; i < WIDTH; i++) skew[i] = int'(cfg[4*i +: 4]);
    endtask

    task automatic send(input int seed, input int cnt, input logic gapped, input logic push);
        logic fr;
        for (int s = 0; s < cnt; s++) begin
            fr = !gapped || (s % 2 == 0);
            step(8'h3C ^ 8'(seed * 37 + s * 19), fr, 1'b0, push && fr);
        end
        for (int s = 0; s < 12; s++) step(8'h00, 1'b0, 1'b0, 1'b0);
    endtask

    initial begin
        int n;
        int r0;
        for (int j = 0; j < HDEP; j++) hist[j] = IDLE;
        set_skew(32'h01020304);

        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(!data_vld && !cal_done && !cal_fail, "R1 outputs during reset",
            {data_vld, cal_done, cal_fail}, 0);
        rst = 1'b0;
        step(IDLE, 1'b0, 1'b0, 1'b0);
        chk(!data_vld && !cal_done && !cal_fail, "R1 outputs after reset",
            {data_vld, cal_done, cal_fail}, 0);

        // R1: boot run needs no trigger
        train();
        n = 0; wait_done(n);
        chk(cal_done && !cal_fail, "R1 boot calibration done", {cal_done, cal_fail}, 2);
        chk(n == 9, "R1 boot done cycle", n, 9);
        exp_lat = 5;
        send(99, 3, 1'b0, 1'b1);
        chk(rd == wr, "R3 boot words delivered", rd, wr);

        // Table of skew patterns, each with a recalibration
        for (int e = 0; e < 5; e++) begin
            set_skew(VEC[e][31:0]);
            fire(int'(VEC[e][37:36]));
            step(IDLE, 1'b0, 1'b0, 1'b0);
            chk(!cal_done && !cal_fail, "R5 run started by trigger", {cal_done, cal_fail}, 0);
            train();
            n = 0; wait_done(n);
            chk(cal_done && !cal_fail, "R5 recalibration done", {cal_done, cal_fail}, 2);
            chk(n == 9, "R7 undisturbed commit cycle", n, 9);
            exp_lat = int'(VEC[e][35:32]) + 1;
            send(e, 6, (e % 2) == 1, 1'b1);
            chk(rd == wr, "R3 all table words delivered", rd, wr);
        end

        // R6: frames presented during a run are never strobed
        r0 = recv;
        fire(2);
        send(40, 4, 1'b0, 1'b0);
        train();
        n = 0; wait_done(n);
        chk(recv == r0, "R6 frames during run suppressed", recv - r0, 0);

        // R7: frames right behind the marker defer the commit
        set_skew(32'h00000000);
        fire(0);
        for (int j = 0; j < HDEP; j++) step(IDLE, 1'b0, 1'b0, 1'b0);
        r0 = recv;
        step(TRAIN, 1'b0, 1'b1, 1'b0);
        n = 0;
        for (int j = 0; j < 3; j++) begin
            step(8'h5A ^ 8'(j), 1'b1, 1'b0, 1'b0);
            n++;
        end
        wait_done(n);
        chk(n == 12, "R7 deferred commit cycle", n, 12);
        chk(cal_done && !cal_fail, "R7 commit after drain", {cal_done, cal_fail}, 2);
        exp_lat = 1;
        send(50, 3, 1'b0, 1'b1);
        chk(recv - r0 == 3, "R7 in-flight frames dropped, later frames kept", recv - r0, 3);

        // R8: a wire beyond the range fails the run
        set_skew(32'h00009000);
        fire(1);
        train();
        n = 0; wait_done(n);
        chk(cal_fail && !cal_done, "R8 fail flag", {cal_done, cal_fail}, 1);
        chk(n == 8, "R8 fail cycle", n, 8);
        r0 = recv;
        send(60, 4, 1'b0, 1'b0);
        chk(recv == r0 && !data_vld, "R8 no delivery after fail", recv - r0, 0);

        // R9: recovery
        set_skew(32'h00002000);
        fire(2);
        step(IDLE, 1'b0, 1'b0, 1'b0);
        chk(!cal_fail, "R9 fail cleared at start", int'(cal_fail), 0);
        train();
        n = 0; wait_done(n);
        chk(cal_done && !cal_fail, "R9 recovered", {cal_done, cal_fail}, 2);
        exp_lat = 3;
        r0 = recv;
        send(70, 5, 1'b1, 1'b1);
        chk(recv - r0 == 3 && rd == wr, "R9 delivery restored", recv - r0, 3);

        if (!finished) begin
            finished = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end
endmodule